// File: doc/BRIEF.md
# ADC Emulation Pattern, Spy and Pulse Buffers

This block is a bank of three test memories for a front-end board. A host feeds it through a byte-wide register port. The **pattern memory** holds 96-bit words, each made of eight 12-bit channel samples. It is filled by the host one byte at a time. It is then replayed, one word per sample strobe, as emulated ADC data. The **spy memory** has the same shape. It records real or processed samples at the sample strobe, and the host reads it back afterwards one byte at a time. The **pulse memory** holds one trigger bit per channel for each sample step, and it replays them as single-cycle pulses.

Each memory has an owner, chosen by its own bit of a setup word. When the bit is 0, the host owns the memory and may write or read it. When the bit is 1, the sampling side owns it and host strobes to that memory are ignored. The block runs from one clock. A one-cycle `sample_en` strobe stands in for the sampling-rate clock. Each memory keeps its own word pointer. The pointer returns to zero whenever the memory's owner bit changes, so a host load or a replay always starts at word 0.

Top module: `adc_test_buffers`

## Requirements
- R1: After reset, `pat_word`, `pulse_out` and `host_rdata` are zero, and `spy_full` is 0.
- R2: A host write to register 0x1C with setup bit 9 at 0 stages one byte. The first byte is bits 7:0 of the word. After the twelfth byte, the 96-bit word is stored at the pattern pointer and the pointer advances, wrapping from 511 to 0.
- R3: A host read of a wide memory returns one byte per `host_rd` strobe on `host_rdata` in the following cycle, least-significant byte first. After the twelfth byte, the pointer advances.
- R4: With setup bit 9 at 1, each `sample_en` puts the word at the pattern pointer on `pat_word` in the following cycle and advances the pointer. Replay wraps from word 511 back to word 0.
- R5: With setup bit 8 at 1, each `sample_en` stores `adc_in` into the spy memory at its pointer. A host read at register 0x06 with bit 8 at 0 returns the stored words in capture order.
- R6: After 512 captures, `spy_full` is 1 and later samples are discarded; words already captured are not overwritten.
- R7: Any change of a memory's setup bit resets that memory's pointer and byte position to zero and clears `spy_full`. A partly staged word is dropped.
- R8: With setup bit 10 at 0, each host write to register 0x1F stores one byte in the pulse memory, and each host read there returns one byte; either advances the pulse pointer. With bit 10 at 1, each `sample_en` drives the stored byte onto `pulse_out` for exactly one cycle. `pulse_out` is zero in every cycle not preceded by a strobe, and the pointer wraps at 512.
- R9: Host strobes to any other register address change no memory. A read there returns zero on `host_rdata`.
- R10: Host writes and reads to a memory whose setup bit is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| setup | input | 16 | Setup word; bit 8 owns spy, bit 9 owns pattern, bit 10 owns pulse |
| host_addr | input | 8 | Host register address |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe, one byte per cycle |
| host_rdata | output | 8 | Read byte, valid the cycle after the strobe |
| sample_en | input | 1 | Sample-rate strobe |
| adc_in | input | 96 | Samples captured into the spy memory |
| pat_word | output | 96 | Replayed pattern word |
| pulse_out | output | 8 | One-cycle trigger bits, one per channel |
| spy_full | output | 1 | Spy capture reached the memory depth |

## Verification
The bench builds the block with its default parameters: eight 12-bit channels, byte-wide host data and a depth of 512. With these values the bench reaches every depth boundary in a short run. It fills all 512 pattern words, replays past the wrap, captures exactly 512 spy samples and then pushes extra ones into a full memory, and replays 512 pulse bytes and then some. With a twelve-byte word, the bench also reaches the byte-order and partial-word cases on every wide access.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;
   localparam int unsigned CH_NUM      = 8;
   localparam int unsigned SAMPLE_BITS = 12;
   localparam int unsigned HOST_BITS   = 8;
   localparam int unsigned BUF_DEPTH   = 512;
   localparam int unsigned SETUP_BITS  = 16;

   localparam logic [7:0] REG_PATTERN = 8'h1C;
   localparam logic [7:0] REG_SPY     = 8'h06;
   localparam logic [7:0] REG_PULSE   = 8'h1F;

   localparam int unsigned OWN_SPY     = 8;
   localparam int unsigned OWN_PATTERN = 9;
   localparam int unsigned OWN_PULSE   = 10;

   typedef enum logic [1:0] {
      SRC_NONE,
      SRC_PATTERN,
      SRC_SPY,
      SRC_PULSE
   } rd_src_e;
endpackage

// File: rtl/byte_stager.sv
module byte_stager #(
   parameter int unsigned WORD_W = 96,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned NB = WORD_W / BYTE_W,
   localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     step,
   input  logic                     load,
   input  logic [BYTE_W-1:0]        byte_in,
   output logic [IW-1:0]            idx,
   output logic                     last,
   output logic [WORD_W-BYTE_W-1:0] stage
);
   assign last = (idx == IW'(NB - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        idx <= '0;
      else if (clr)      idx <= '0;
      else if (step)     idx <= last ? '0 : idx + 1'b1;
   end

   for (genvar g = 0; g < NB - 1; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stage[g*BYTE_W +: BYTE_W] <= '0;
         else if (!clr && step && load && idx == IW'(g))
            stage[g*BYTE_W +: BYTE_W] <= byte_in;
      end
   end

   a_r3_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= IW'(NB - 1));
   a_r7_idx_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> idx == '0);
endmodule

// File: rtl/wide_buffer.sv
module wide_buffer #(
   parameter int unsigned WORD_W     = 96,
   parameter int unsigned BYTE_W     = 8,
   parameter int unsigned DEPTH      = 512,
   parameter bit          SMP_WRITES = 1'b0,
   localparam int unsigned NB = WORD_W / BYTE_W,
   localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              owner_smp,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [BYTE_W-1:0] host_byte,
   input  logic              smp_en,
   input  logic [WORD_W-1:0] smp_word,
   output logic [BYTE_W-1:0] rd_byte,
   output logic [WORD_W-1:0] word_out,
   output logic              full
);
   logic                     owner_q;
   logic                     chg, host_ok, hw, hr, smp_go;
   logic [AW-1:0]            ptr, ptr_next;
   logic [IW-1:0]            idx;
   logic                     last;
   logic [WORD_W-BYTE_W-1:0] stage;
   logic [WORD_W-1:0]        host_word, cur_word;
   logic                     mem_we, smp_step;
   logic [WORD_W-1:0]        mem_wd;
   logic [WORD_W-1:0]        mem [DEPTH];

   assign chg       = owner_smp ^ owner_q;
   assign host_ok   = !owner_smp && !chg;
   assign hw        = host_ok && host_wr;
   assign hr        = host_ok && host_rd && !host_wr;
   assign smp_go    = owner_smp && !chg && smp_en;
   assign ptr_next  = (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
   assign host_word = {host_byte, stage};
   assign cur_word  = mem[ptr];

   byte_stager #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (chg),
      .step    (hw || hr),
      .load    (hw),
      .byte_in (host_byte),
      .idx     (idx),
      .last    (last),
      .stage   (stage)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) owner_q <= 1'b0;
      else        owner_q <= owner_smp;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        ptr <= '0;
      else if (chg)                      ptr <= '0;
      else if (((hw || hr) && last) || smp_step) ptr <= ptr_next;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rd_byte <= '0;
      else if (hr) rd_byte <= cur_word[int'(idx)*BYTE_W +: BYTE_W];
   end

   always_ff @(posedge clk) begin
      if (mem_we) mem[ptr] <= mem_wd;
   end

   if (SMP_WRITES) begin : g_capture
      logic full_q;
      assign smp_step = smp_go && !full_q;
      assign mem_we   = (hw && last) || smp_step;
      assign mem_wd   = smp_go ? smp_word : host_word;
      assign word_out = '0;
      assign full     = full_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               full_q <= 1'b0;
         else if (chg)                             full_q <= 1'b0;
         else if (smp_step && ptr == AW'(DEPTH - 1)) full_q <= 1'b1;
      end

      a_r6_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
         full_q |-> !mem_we);
      a_r6_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (full_q && owner_smp && owner_q) |=> full_q);
   end else begin : g_replay
      logic [WORD_W-1:0] word_q;
      logic              unused_smp;
      assign unused_smp = ^smp_word;
      assign smp_step   = smp_go;
      assign mem_we     = hw && last;
      assign mem_wd     = host_word;
      assign word_out   = word_q;
      assign full       = 1'b0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      word_q <= '0;
         else if (smp_go) word_q <= cur_word;
      end

      a_r4_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
         !smp_en |=> $stable(word_q));
   end

   a_r7_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> ptr == '0);
   a_r10_host_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_smp && owner_q && !smp_en) |=> $stable(ptr));
endmodule

// File: rtl/pulse_buffer.sv
module pulse_buffer #(
   parameter int unsigned CH     = 8,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned DEPTH  = 512,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              owner_smp,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [BYTE_W-1:0] host_byte,
   input  logic              smp_en,
   output logic [BYTE_W-1:0] rd_byte,
   output logic [CH-1:0]     pulse
);
   logic          owner_q, chg, host_ok, hw, hr, smp_go;
   logic [AW-1:0] ptr, ptr_next;
   logic [CH-1:0] mem [DEPTH];

   assign chg      = owner_smp ^ owner_q;
   assign host_ok  = !owner_smp && !chg;
   assign hw       = host_ok && host_wr;
   assign hr       = host_ok && host_rd && !host_wr;
   assign smp_go   = owner_smp && !chg && smp_en;
   assign ptr_next = (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) owner_q <= 1'b0;
      else        owner_q <= owner_smp;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   ptr <= '0;
      else if (chg)                 ptr <= '0;
      else if (hw || hr || smp_go)  ptr <= ptr_next;
   end

   always_ff @(posedge clk) begin
      if (hw) mem[ptr] <= host_byte[CH-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rd_byte <= '0;
      else if (hr) rd_byte <= BYTE_W'(mem[ptr]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pulse <= '0;
      else if (smp_go) pulse <= mem[ptr];
      else             pulse <= '0;
   end

   a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_en |=> pulse == '0);
   a_r7_pulse_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> ptr == '0);
endmodule

// File: rtl/adc_test_buffers.sv
module adc_test_buffers
   import adc_emu_pkg::*;
#(
   parameter int unsigned CH        = CH_NUM,
   parameter int unsigned SAMPLE_W  = SAMPLE_BITS,
   parameter int unsigned BYTE_W    = HOST_BITS,
   parameter int unsigned DEPTH     = BUF_DEPTH,
   parameter int unsigned SETUP_W   = SETUP_BITS,
   parameter logic [7:0]  ADDR_PAT  = REG_PATTERN,
   parameter logic [7:0]  ADDR_SPY  = REG_SPY,
   parameter logic [7:0]  ADDR_PLS  = REG_PULSE,
   localparam int unsigned WORD_W = CH * SAMPLE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SETUP_W-1:0] setup,
   input  logic [7:0]         host_addr,
   input  logic               host_wr,
   input  logic [BYTE_W-1:0]  host_wdata,
   input  logic               host_rd,
   output logic [BYTE_W-1:0]  host_rdata,
   input  logic               sample_en,
   input  logic [WORD_W-1:0]  adc_in,
   output logic [WORD_W-1:0]  pat_word,
   output logic [CH-1:0]      pulse_out,
   output logic               spy_full
);
   if (WORD_W % BYTE_W != 0) begin : g_bad_word
      $error("sample word must be a whole number of host bytes");
   end
   if (WORD_W / BYTE_W < 2) begin : g_bad_bytes
      $error("sample word must span at least two host bytes");
   end
   if (CH > BYTE_W) begin : g_bad_ch
      $error("pulse channels must fit in one host byte");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("buffer depth must be at least two");
   end
   if (SETUP_W <= OWN_PULSE) begin : g_bad_setup
      $error("setup word too narrow for owner bits");
   end

   logic        sel_pat, sel_spy, sel_pls, sel_any;
   rd_src_e     rd_src;
   logic [BYTE_W-1:0] rd_pat, rd_spy, rd_pls;
   logic [WORD_W-1:0] spy_unused_word;
   logic        pat_unused_full;
   logic        unused_setup;

   assign unused_setup = ^setup;
   assign sel_pat = (host_addr == ADDR_PAT);
   assign sel_spy = (host_addr == ADDR_SPY);
   assign sel_pls = (host_addr == ADDR_PLS);
   assign sel_any = sel_pat || sel_spy || sel_pls;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_src <= SRC_NONE;
      else if (host_rd) rd_src <= sel_pat ? SRC_PATTERN :
                                  sel_spy ? SRC_SPY :
                                  sel_pls ? SRC_PULSE : SRC_NONE;
   end

   always_comb begin
      unique case (rd_src)
         SRC_PATTERN: host_rdata = rd_pat;
         SRC_SPY:     host_rdata = rd_spy;
         SRC_PULSE:   host_rdata = rd_pls;
         default:     host_rdata = '0;
      endcase
   end

   wide_buffer #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .DEPTH(DEPTH), .SMP_WRITES(1'b0)) u_pattern (
      .clk       (clk),
      .rst_n     (rst_n),
      .owner_smp (setup[OWN_PATTERN]),
      .host_wr   (host_wr && sel_pat),
      .host_rd   (host_rd && sel_pat),
      .host_byte (host_wdata),
      .smp_en    (sample_en),
      .smp_word  (adc_in),
      .rd_byte   (rd_pat),
      .word_out  (pat_word),
      .full      (pat_unused_full)
   );

   wide_buffer #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .DEPTH(DEPTH), .SMP_WRITES(1'b1)) u_spy (
      .clk       (clk),
      .rst_n     (rst_n),
      .owner_smp (setup[OWN_SPY]),
      .host_wr   (host_wr && sel_spy),
      .host_rd   (host_rd && sel_spy),
      .host_byte (host_wdata),
      .smp_en    (sample_en),
      .smp_word  (adc_in),
      .rd_byte   (rd_spy),
      .word_out  (spy_unused_word),
      .full      (spy_full)
   );

   pulse_buffer #(.CH(CH), .BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_pulse (
      .clk       (clk),
      .rst_n     (rst_n),
      .owner_smp (setup[OWN_PULSE]),
      .host_wr   (host_wr && sel_pls),
      .host_rd   (host_rd && sel_pls),
      .host_byte (host_wdata),
      .smp_en    (sample_en),
      .rd_byte   (rd_pls),
      .pulse     (pulse_out)
   );

   a_r9_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !sel_any) |=> host_rdata == '0);
   a_r6_spy_full_only_capturing: assert property (@(posedge clk) disable iff (!rst_n)
      spy_full |-> setup[OWN_SPY] || $past(setup[OWN_SPY]));
endmodule

// File: tb/adc_test_buffers_test.sv
module adc_test_buffers_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] setup = '0;
   logic [7:0]  host_addr = '0;
   logic        host_wr = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic        host_rd = 1'b0;
   logic [7:0]  host_rdata;
   logic        sample_en = 1'b0;
   logic [95:0] adc_in = '0;
   logic [95:0] pat_word;
   logic [7:0]  pulse_out;
   logic        spy_full;

   int n_chk = 0;
   int n_fail = 0;
   logic [95:0] pm [512];
   logic [95:0] sm [512];
   logic [7:0]  pb [512];

   always #2.5 clk = ~clk;

   adc_test_buffers uut (
      .clk(clk), .rst_n(rst_n), .setup(setup), .host_addr(host_addr),
      .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
      .host_rdata(host_rdata), .sample_en(sample_en), .adc_in(adc_in),
      .pat_word(pat_word), .pulse_out(pulse_out), .spy_full(spy_full)
   );

   function automatic logic [95:0] rnd96();
      return {$urandom, $urandom, $urandom};
   endfunction

   task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic hwrite(input logic [7:0] a, input logic [7:0] d);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hread(input logic [7:0] a, output logic [7:0] d);
      host_addr = a; host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
      d = host_rdata;
   endtask

   task automatic hwrite_word(input logic [7:0] a, input logic [95:0] w);
      for (int b = 0; b < 12; b++) hwrite(a, w[b*8 +: 8]);
   endtask

   task automatic hread_word(input logic [7:0] a, output logic [95:0] w);
      logic [7:0] d;
      for (int b = 0; b < 12; b++) begin
         hread(a, d);
         w[b*8 +: 8] = d;
      end
   endtask

   task automatic sample(input logic [95:0] d);
      adc_in = d; sample_en = 1'b1;
      @(negedge clk);
      sample_en = 1'b0;
   endtask

   task automatic set_own(input int bitpos, input logic v);
      setup[bitpos] = v;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [95:0] w;
      logic [7:0]  d;
      void'($urandom(32'd1234));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 pat_word", pat_word, '0);
      check("R1 pulse_out", {88'd0, pulse_out}, '0);
      check("R1 spy_full", {95'd0, spy_full}, '0);
      check("R1 host_rdata", {88'd0, host_rdata}, '0);

      // R2 fill pattern memory, pointer wraps to 0
      for (int i = 0; i < 512; i++) begin
         pm[i] = rnd96();
         hwrite_word(8'h1C, pm[i]);
      end
      // R3 byte-serial readback
      for (int i = 0; i < 4; i++) begin
         hread_word(8'h1C, w);
         check("R2 R3 pattern readback", w, pm[i]);
      end

      // R7 partial word dropped on owner change
      for (int b = 0; b < 5; b++) hwrite(8'h1C, 8'hA5);
      set_own(9, 1'b1);
      // R10 host write while sampler owns pattern
      hwrite_word(8'h1C, 96'hDEAD_BEEF_0123_4567_89AB_CDEF);
      for (int i = 0; i < 520; i++) begin
         sample('0);
         check("R4 replay word", pat_word, pm[i % 512]);
      end
      check("R4 hold after strobe", pat_word, pm[7]);
      set_own(9, 1'b0);

      // R9 unmapped address
      hwrite_word(8'h55, 96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF);
      hread(8'h55, d);
      check("R9 unmapped read", {88'd0, d}, '0);
      hread_word(8'h1C, w);
      check("R7 R9 R10 word0 intact", w, pm[0]);

      // R5 R6 spy capture
      set_own(8, 1'b1);
      for (int i = 0; i < 512; i++) begin
         sm[i] = rnd96();
         sample(sm[i]);
         if (i == 510) check("R6 not full yet", {95'd0, spy_full}, '0);
      end
      check("R6 full raised", {95'd0, spy_full}, 96'd1);
      for (int i = 0; i < 3; i++) sample(rnd96());
      check("R6 full held", {95'd0, spy_full}, 96'd1);
      hread(8'h06, d);
      check("R10 spy read blocked", {88'd0, d}, '0);
      set_own(8, 1'b0);
      check("R7 full cleared", {95'd0, spy_full}, '0);
      for (int i = 0; i < 512; i++) begin
         hread_word(8'h06, w);
         check("R5 R6 spy readback", w, sm[i]);
      end

      // R8 pulse memory
      for (int i = 0; i < 512; i++) begin
         pb[i] = 8'($urandom);
         hwrite(8'h1F, pb[i]);
      end
      hread(8'h1F, d);
      check("R8 pulse read0", {88'd0, d}, {88'd0, pb[0]});
      hread(8'h1F, d);
      check("R8 pulse read1", {88'd0, d}, {88'd0, pb[1]});
      set_own(10, 1'b1);
      for (int i = 0; i < 514; i++) begin
         sample('0);
         check("R8 pulse value", {88'd0, pulse_out}, {88'd0, pb[i % 512]});
         @(negedge clk);
         check("R8 pulse one cycle", {88'd0, pulse_out}, '0);
      end
      set_own(10, 1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule